// File: doc/BRIEF.md
# Single-Data-Phase PCI Target

This block is a 32-bit PCI bus target clocked by the 33 MHz bus clock. It watches each address phase and claims configuration, I/O and memory transactions that decode to it. Every transaction it claims completes in exactly one data phase. It holds a small configuration header with one 16-byte I/O window and one 256 KB memory window. Each window is enabled by its own bit in the command register. The bus pins are split into separate input, output and output-enable signals, so the chip's pad ring builds the tri-state and open-drain drivers.

Accepted I/O and memory accesses are passed to a local port as one-cycle request pulses. A read request goes out when the target claims the transaction. The local side must then supply read data within a fixed number of clocks, set by the `TRDY_WAIT` parameter. A write request goes out when the data phase completes. If the master tries a burst, the target disconnects it after the first data phase. A local active-low interrupt is turned into the enable for the open-drain interrupt pin.

Top module: `pci_target_single`

## Requirements
- R1: While `rst_n` is low, `devsel_n`, `trdy_n` and `stop_n` are high. `tgt_oe`, `ad_oe`, `par_oe`, `lreq` and `int_oe` are low.
- R2: A configuration transaction is claimed only if all three hold at the address phase: `idsel` is high, the command is 4'b1010 (read) or 4'b1011 (write), and AD[1:0] is 00. For any claim, `devsel_n` goes low, with `tgt_oe` high, in the second clock after the address phase (medium decode). An unclaimed transaction leaves `devsel_n` high and `tgt_oe` low.
- R3: A configuration read returns a header dword chosen by AD[7:2]:
  - dword 0: {device id, vendor id}
  - dword 1: {16'h0200, 14'b0, mem enable, io enable}
  - dword 2: {class code, revision}
  - dword 4: {io base[31:4], 4'b0001}
  - dword 5: {mem base[31:18], 18'b0}
  - dword 11: {subsystem id, subsystem vendor id}
  - dword 15: {16'h0000, 8'h01, interrupt line}
  - every other dword, including 3 (which holds BIST) and 12 (the expansion ROM register), reads as zero.
  Configuration writes update only the bytes whose byte enable is asserted. Command bit 0 is the I/O enable and bit 1 is the memory enable.
- R4: I/O read (4'b0010) and I/O write (4'b0011) are claimed only when the I/O enable is 1 and AD[31:4] equals the I/O base.
- R5: Memory read (4'b0110) and memory write (4'b0111) are claimed only when the memory enable is 1 and AD[31:18] equals the memory base.
- R6: `trdy_n` goes low TRDY_WAIT+1 clocks after `devsel_n` goes low. For a local read, `lreq` pulses in the first DEVSEL cycle with `lwe`=0, `laddr`=the address, `lbe`=the byte enables and `lio`=1 for I/O space. `ad_out` carries the value of `lrdata` from the clock edge that asserts `trdy_n` (or the header dword for a configuration read).
- R7: A local write produces a one-cycle `lreq` with `lwe`=1, `lwdata`=AD and `lbe`=~C/BE#. It appears in the clock after the data phase completes (IRDY# and TRDY# both low).
- R8: `par_out` is the even parity of `ad_out` and C/BE#, registered one clock later. `par_oe` follows `ad_oe` one clock later. `ad_oe` is high only during claimed reads.
- R9: If FRAME# is still low when `trdy_n` is asserted, `stop_n` is asserted with it. After the single transfer, `trdy_n` rises, while `stop_n` and `devsel_n` stay low until FRAME# rises.
- R10: When a transaction ends, `devsel_n`, `trdy_n` and `stop_n` are driven high for one clock with `tgt_oe` still high. In the next clock `tgt_oe` is released.
- R11: `int_oe` (pull INTA# low) equals the inverse of `loc_irq_n` sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| idsel | input | 1 | Configuration select |
| cbe_n_in | input | 4 | C/BE# from the bus |
| ad_in | input | 32 | AD as received from the bus |
| ad_out | output | 32 | AD value driven on reads |
| ad_oe | output | 1 | AD output enable |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | PAR output enable |
| devsel_n | output | 1 | DEVSEL# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| tgt_oe | output | 1 | Shared enable for DEVSEL#, TRDY# and STOP# |
| loc_irq_n | input | 1 | Local interrupt, active low |
| int_oe | output | 1 | Pull INTA# low when high |
| lreq | output | 1 | Local request pulse |
| lwe | output | 1 | Local request is a write |
| lio | output | 1 | Local request targets I/O space |
| laddr | output | 32 | Local request address |
| lbe | output | 4 | Local byte enables, active high |
| lwdata | output | 32 | Local write data |
| lrdata | input | 32 | Local read data, valid TRDY_WAIT+1 clocks after a read lreq |

## Verification
Configuration reads are tried in three forms: a correct access, an access with IDSEL low, and an access with AD[1:0] non-zero. Only the correct form may claim. I/O and memory accesses are sent to addresses inside each window, just past its top edge, and before the enable bit is set. This separates base comparison from enable gating. Writing all ones to the base registers and doing partial byte-enable writes shows the read-only low bits and per-byte updates. A burst attempt is set against a single phase to tell disconnect behaviour apart from a normal finish, and every bus output is compared on every clock against a timeline built in the bench.

// File: rtl/pci_target_single.sv
module pci_target_single #(
  parameter logic [15:0] VENDOR_ID  = 16'h1BAD,
  parameter logic [15:0] DEVICE_ID  = 16'h0C01,
  parameter logic [15:0] SUBVEN_ID  = 16'h1BAD,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter int          IO_BITS    = 4,
  parameter int          MEM_BITS   = 18,
  parameter int          TRDY_WAIT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n_in,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        tgt_oe,
  input  logic        loc_irq_n,
  output logic        int_oe,
  output logic        lreq,
  output logic        lwe,
  output logic        lio,
  output logic [31:0] laddr,
  output logic [3:0]  lbe,
  output logic [31:0] lwdata,
  input  logic [31:0] lrdata
);
  localparam int CW = $clog2(TRDY_WAIT + 2);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_WAIT, S_DATA, S_DISC, S_TURN} st_t;
  st_t st;

  logic              frame_q, idsel_q, is_cfg;
  logic [31:0]       addr_q;
  logic [3:0]        cmd_q;
  logic [CW-1:0]     cnt;
  logic              io_en, mem_en;
  logic [31:IO_BITS] io_base;
  logic [31:MEM_BITS] mem_base;
  logic [7:0]        int_line;
  logic [31:0]       cfg_rdata;

  wire is_rd   = ~cmd_q[0];
  wire io_hit  = (cmd_q[3:1] == 3'b001) && io_en  && (addr_q[31:IO_BITS]  == io_base);
  wire mem_hit = (cmd_q[3:1] == 3'b011) && mem_en && (addr_q[31:MEM_BITS] == mem_base);
  wire cfg_hit = (cmd_q[3:1] == 3'b101) && idsel_q && (addr_q[1:0] == 2'b00);
  wire any_hit = io_hit | mem_hit | cfg_hit;
  wire xfer    = (st == S_DATA) && !irdy_n;
  wire cfg_wr  = xfer && is_cfg && cmd_q[0];
  wire [3:0] be = ~cbe_n_in;

  always_comb begin
    case (addr_q[7:2])
      6'd0:    cfg_rdata = {DEVICE_ID, VENDOR_ID};
      6'd1:    cfg_rdata = {16'h0200, 14'b0, mem_en, io_en};
      6'd2:    cfg_rdata = {CLASS_CODE, REVISION};
      6'd4:    cfg_rdata = {io_base, {(IO_BITS-1){1'b0}}, 1'b1};
      6'd5:    cfg_rdata = {mem_base, {MEM_BITS{1'b0}}};
      6'd11:   cfg_rdata = {SUBSYS_ID, SUBVEN_ID};
      6'd15:   cfg_rdata = {16'h0000, 8'h01, int_line};
      default: cfg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en    <= 1'b0;
      mem_en   <= 1'b0;
      io_base  <= '0;
      mem_base <= '0;
      int_line <= 8'h00;
    end else if (cfg_wr) begin
      case (addr_q[7:2])
        6'd1:  if (be[0]) begin io_en <= ad_in[0]; mem_en <= ad_in[1]; end
        6'd4:  for (int i = IO_BITS; i < 32; i++) if (be[i/8]) io_base[i] <= ad_in[i];
        6'd5:  for (int i = MEM_BITS; i < 32; i++) if (be[i/8]) mem_base[i] <= ad_in[i];
        6'd15: if (be[0]) int_line <= ad_in[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      frame_q  <= 1'b1;
      addr_q   <= '0;
      cmd_q    <= '0;
      idsel_q  <= 1'b0;
      is_cfg   <= 1'b0;
      cnt      <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      tgt_oe   <= 1'b0;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      lreq     <= 1'b0;
      lwe      <= 1'b0;
      lio      <= 1'b0;
      laddr    <= '0;
      lbe      <= '0;
      lwdata   <= '0;
    end else begin
      frame_q <= frame_n;
      lreq    <= 1'b0;
      case (st)
        S_IDLE: if (frame_q && !frame_n) begin
          addr_q  <= ad_in;
          cmd_q   <= cbe_n_in;
          idsel_q <= idsel;
          st      <= S_DEC;
        end
        S_DEC: if (any_hit) begin
          devsel_n <= 1'b0;
          tgt_oe   <= 1'b1;
          ad_oe    <= is_rd;
          is_cfg   <= cfg_hit;
          cnt      <= CW'(TRDY_WAIT);
          st       <= S_WAIT;
          if (!cfg_hit) begin
            laddr <= addr_q;
            lio   <= io_hit;
            lbe   <= be;
            lwe   <= 1'b0;
            lreq  <= is_rd;
          end
        end else begin
          st <= S_IDLE;
        end
        S_WAIT: if (cnt == '0) begin
          trdy_n <= 1'b0;
          stop_n <= frame_n;
          if (is_rd) ad_out <= is_cfg ? cfg_rdata : lrdata;
          st <= S_DATA;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_DATA: if (!irdy_n) begin
          trdy_n <= 1'b1;
          ad_oe  <= 1'b0;
          if (!is_rd && !is_cfg) begin
            lreq   <= 1'b1;
            lwe    <= 1'b1;
            lwdata <= ad_in;
            lbe    <= be;
          end
          if (frame_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            st       <= S_TURN;
          end else begin
            stop_n <= 1'b0;
            st     <= S_DISC;
          end
        end else begin
          stop_n <= frame_n;
        end
        S_DISC: if (frame_n) begin
          devsel_n <= 1'b1;
          stop_n   <= 1'b1;
          st       <= S_TURN;
        end
        S_TURN: begin
          tgt_oe <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
      int_oe  <= 1'b0;
    end else begin
      par_out <= ^{ad_out, cbe_n_in};
      par_oe  <= ad_oe;
      int_oe  <= ~loc_irq_n;
    end
  end
endmodule

// File: rtl/pci_target_single_chk.sv
module pci_target_single_chk (
  input logic clk,
  input logic rst_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic tgt_oe,
  input logic ad_oe,
  input logic par_oe,
  input logic lreq,
  input logic loc_irq_n,
  input logic int_oe
);
  assert_trdy_claimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  assert_stop_claimed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n);
  assert_single_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n) |=> trdy_n);
  assert_released_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_oe |-> (devsel_n && trdy_n && stop_n));
  assert_par_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe);
  assert_par_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |=> !par_oe);
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lreq |=> !lreq);
  assert_int_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_irq_n |=> int_oe);
  assert_int_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loc_irq_n |=> !int_oe);
endmodule

bind pci_target_single pci_target_single_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .devsel_n(devsel_n),
  .trdy_n(trdy_n), .stop_n(stop_n), .tgt_oe(tgt_oe), .ad_oe(ad_oe),
  .par_oe(par_oe), .lreq(lreq), .loc_irq_n(loc_irq_n), .int_oe(int_oe)
);

// File: tb/tb_pci_target_single.sv
`timescale 1ns/1ps
module tb_pci_target_single;
  localparam int W = 2;
  localparam logic [31:0] KEY = 32'hA5A5_0F0F;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, loc_irq_n = 1'b1;
  logic [3:0] cbe_n_in = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out, laddr, lwdata, lrdata;
  logic ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, tgt_oe, int_oe, lreq, lwe, lio;
  logic [3:0] lbe;

  assign lrdata = laddr ^ KEY;

  pci_target_single #(.TRDY_WAIT(W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n_in(cbe_n_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .tgt_oe(tgt_oe), .loc_irq_n(loc_irq_n), .int_oe(int_oe),
    .lreq(lreq), .lwe(lwe), .lio(lio), .laddr(laddr), .lbe(lbe),
    .lwdata(lwdata), .lrdata(lrdata)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_bar0 = 32'h0, m_bar1 = 32'h0;
  logic [1:0]  m_cmd = 2'b00;
  logic [7:0]  m_line = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int idx);
    case (idx)
      0:  return {16'h0C01, 16'h1BAD};
      1:  return {16'h0200, 14'b0, m_cmd};
      2:  return {24'h118000, 8'h01};
      4:  return m_bar0 | 32'h1;
      5:  return m_bar1;
      11: return {16'h0001, 16'h1BAD};
      15: return {16'h0, 8'h01, m_line};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be, input logic [31:0] mask);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r & mask;
  endfunction

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] wd,
                     input logic [3:0] be, input bit sel, input bit burst, input bit hit,
                     input logic [31:0] rexp, input string tag, input bit loc);
    bit rd = !cmd[0];
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n_in = cmd; idsel = sel;
    @(negedge clk);
    chk({tag, " R2 no devsel in decode"}, devsel_n, 1);
    ad_in = rd ? 32'h0 : wd; cbe_n_in = ~be; irdy_n = 0; frame_n = burst ? 1'b0 : 1'b1; idsel = 0;
    @(negedge clk);
    chk({tag, " R2 devsel"}, devsel_n, !hit);
    chk({tag, " R2 tgt_oe"}, tgt_oe, hit);
    chk({tag, " R6 read lreq"}, lreq, hit && rd && loc);
    chk({tag, " R8 ad_oe"}, ad_oe, hit && rd);
    if (!hit) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk({tag, " R2 unclaimed"}, {devsel_n, tgt_oe}, 2'b10);
      end
      frame_n = 1; irdy_n = 1;
      @(negedge clk);
      return;
    end
    if (loc) begin
      chk({tag, " R6 laddr"}, laddr, addr);
      chk({tag, " R6 lbe"}, lbe, be);
      chk({tag, " R6 lio"}, lio, cmd[3:1] == 3'b001);
    end
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      chk({tag, " R6 trdy wait"}, {trdy_n, devsel_n, stop_n}, 3'b101);
    end
    @(negedge clk);
    chk({tag, " R6 trdy"}, trdy_n, 0);
    chk({tag, " R9 stop with trdy"}, stop_n, !burst);
    if (rd) chk({tag, " R6 read data"}, ad_out, rexp);
    @(negedge clk);
    chk({tag, " R10 trdy release"}, trdy_n, 1);
    chk({tag, " R8 par_oe"}, par_oe, rd);
    if (rd) chk({tag, " R8 parity"}, par_out, ^{rexp, ~be});
    chk({tag, " R8 ad_oe off"}, ad_oe, 0);
    chk({tag, " R10 oe held"}, tgt_oe, 1);
    if (!rd && loc) begin
      chk({tag, " R7 lreq"}, {lreq, lwe}, 2'b11);
      chk({tag, " R7 lwdata"}, lwdata, wd);
      chk({tag, " R7 lbe"}, lbe, be);
      chk({tag, " R7 laddr"}, laddr, addr);
    end else chk({tag, " R7 no lreq"}, lreq, 0);
    if (burst) begin
      chk({tag, " R9 hold"}, {stop_n, devsel_n}, 2'b00);
      @(negedge clk);
      chk({tag, " R9 still hold"}, {stop_n, devsel_n}, 2'b00);
      frame_n = 1;
      @(negedge clk);
      chk({tag, " R10 turnaround"}, {stop_n, devsel_n, trdy_n, tgt_oe}, 4'b1111);
    end else begin
      chk({tag, " R10 turnaround"}, {stop_n, devsel_n}, 2'b11);
    end
    irdy_n = 1;
    @(negedge clk);
    chk({tag, " R10 oe release"}, tgt_oe, 0);
    if (!rd && !loc) begin
      case (addr[7:2])
        6'd1:  if (be[0]) m_cmd = wd[1:0];
        6'd4:  m_bar0 = merge(m_bar0, wd, be, 32'hFFFF_FFF0);
        6'd5:  m_bar1 = merge(m_bar1, wd, be, 32'hFFFC_0000);
        6'd15: if (be[0]) m_line = wd[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic cfg_rd(input int idx, input string tag);
    txn(4'hA, {24'h0, 6'(idx), 2'b00}, 32'h0, 4'hF, 1, 0, 1, hdr(idx), tag, 0);
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d, input logic [3:0] be, input string tag);
    txn(4'hB, {24'h0, 6'(idx), 2'b00}, d, be, 1, 0, 1, 32'h0, tag, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bus outputs", {devsel_n, trdy_n, stop_n, tgt_oe, ad_oe, par_oe}, 6'b111000);
    chk("R1 reset local", {lreq, int_oe}, 2'b00);
    rst_n = 1;
    @(negedge clk);

    cfg_rd(0, "R3 ids");
    txn(4'hA, 32'h0, 0, 4'hF, 0, 0, 0, 0, "R2 idsel low", 0);
    txn(4'hA, 32'h1, 0, 4'hF, 1, 0, 0, 0, "R2 type1 addr", 0);
    cfg_rd(1, "R3 status/command");
    cfg_rd(2, "R3 class");
    cfg_rd(3, "R3 bist zero");
    cfg_rd(12, "R3 rom zero");
    cfg_rd(11, "R3 subsystem");
    cfg_wr(4, 32'hFFFF_FFFF, 4'hF, "R3 bar0 ones");
    cfg_rd(4, "R3 bar0 mask");
    cfg_wr(5, 32'hFFFF_FFFF, 4'hF, "R3 bar1 ones");
    cfg_rd(5, "R3 bar1 mask");
    cfg_wr(4, 32'h0000_1230, 4'hF, "R3 bar0 set");
    cfg_wr(5, 32'h4000_0000, 4'hF, "R3 bar1 set");
    cfg_wr(5, 32'hFFFF_FFFF, 4'h0, "R3 no byte enables");
    cfg_rd(5, "R3 bar1 unchanged");
    cfg_wr(15, 32'hFFFF_FF55, 4'h1, "R3 int line");
    cfg_rd(15, "R3 int line read");

    txn(4'h2, 32'h1234, 0, 4'hF, 0, 0, 0, 0, "R4 io disabled", 1);
    cfg_wr(1, 32'h1, 4'h1, "R3 io enable");
    txn(4'h6, 32'h4000_0010, 0, 4'hF, 0, 0, 0, 0, "R5 mem disabled", 1);
    cfg_wr(1, 32'h3, 4'h1, "R3 both enables");
    cfg_rd(1, "R3 command read");

    txn(4'h2, 32'h1238, 0, 4'hF, 0, 0, 1, 32'h1238 ^ KEY, "R4 io read", 1);
    txn(4'h3, 32'h123C, 32'hDEAD_BEEF, 4'h6, 0, 0, 1, 0, "R4 io write", 1);
    txn(4'h2, 32'h1240, 0, 4'hF, 0, 0, 0, 0, "R4 io past window", 1);
    txn(4'h7, 32'h4003_FFFC, 32'h1357_9BDF, 4'h3, 0, 0, 1, 0, "R5 mem write top", 1);
    txn(4'h6, 32'h4000_0010, 0, 4'hC, 0, 0, 1, 32'h4000_0010 ^ KEY, "R5 mem read", 1);
    txn(4'h6, 32'h4004_0000, 0, 4'hF, 0, 0, 0, 0, "R5 mem past window", 1);
    txn(4'h6, 32'h4000_0020, 0, 4'hF, 0, 1, 1, 32'h4000_0020 ^ KEY, "R9 burst read", 1);
    txn(4'h7, 32'h4000_0030, 32'h0F0F_1234, 4'hF, 0, 1, 1, 0, "R9 burst write", 1);

    loc_irq_n = 0;
    @(negedge clk);
    chk("R11 int asserted", int_oe, 1);
    @(negedge clk);
    chk("R11 int held", int_oe, 1);
    loc_irq_n = 1;
    @(negedge clk);
    chk("R11 int released", int_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule